// File: doc/BRIEF.md
# Verb-Addressed Scratch Register Pair with Display Interrupt

This block sits on the codec side of an audio link. It holds a pair of 32-bit scratch words that a host reaches through command verbs. Each command carries a node number, a 12-bit verb code and an 8-bit payload. Get-verbs return a whole word. Set-verbs replace one byte of a word at a time. A companion display controller reads the audio format word and its valid flag straight from output pins. It learns about changes through a sticky interrupt flag, which it clears with an acknowledge pin.

Two static inputs pick the operating style.

- `doorbell_mode` chooses how an interrupt is raised:
  - Toggle style (0): an interrupt follows a change of the top bit of word 0.
  - Doorbell style (1): an interrupt follows a dedicated doorbell verb.
- `multi_stream` chooses where the words live:
  - 0: a single register pair answers at node 0x01.
  - 1: every converter node in the `CVT_NODES` parameter list owns a private pair and its own interrupt flag.

The command input uses valid/ready. `cmd_ready` is always high, so the block never applies back-pressure and accepts a command on every cycle in which `cmd_valid` is high. Each accepted command produces exactly one response. The response is a one-cycle `rsp_valid` strobe in the following cycle, with `rsp_data` alongside it. The response side has no ready signal, so the consumer must take the strobe when it comes.

Top module: `vscratch_regs`

## Requirements
- R1: A synchronous active-high reset clears both words of every pair, every interrupt flag, `rsp_valid` and `rsp_data` to zero.
- R2: `cmd_ready` is always 1. A command accepted at clock edge k gives `rsp_valid` = 1 for exactly the cycle after edge k. Verb 0xFA6 returns all 32 bits of word 0 of the addressed pair, and verb 0xFAB returns all 32 bits of word 1.
- R3: Verbs 0xFA7, 0xFA8, 0xFA9 and 0xFAA load the payload into bits [7:0], [15:8], [23:16] and [31:24] of word 0. The other bytes are left unchanged.
- R4: Verbs 0xFAC, 0xFAD, 0xFAE and 0xFAF load the payload into bits [7:0], [15:8], [23:16] and [31:24] of word 1.
- R5: Set-verbs and the doorbell verb respond with zero. A verb or node that is not recognised responds with zero and changes no word and no interrupt flag.
- R6: With `doorbell_mode` = 0, the flag is set by a 0xFAA write whose payload bit 7 differs from the current bit 31 of word 0. A 0xFAA write that leaves bit 31 unchanged does not set it. Verb 0xF80 has no effect in this mode.
- R7: With `doorbell_mode` = 1, bit 31 of word 0 has no trigger effect. Verb 0xF80 with a nonzero payload sets the flag, and with a zero payload it does nothing.
- R8: With `multi_stream` = 0, only node 0x01 addresses pair 0. Any other node is treated as unrecognised.
- R9: With `multi_stream` = 1, the node `CVT_NODES[i]` (default: node 0x04 for i = 0 and node 0x05 for i = 1) addresses pair i, and pairs are independent. Node 0x01 is then unrecognised.
- R10: An interrupt flag stays set until its `irq_ack` bit is high at a clock edge. An acknowledge and a trigger at the same edge leave the flag set.
- R11: `fmt_o[16*i +: 16]` always equals bits [15:0] of word 0 of pair i, and `fmt_valid_o[i]` always equals bit 30 of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| doorbell_mode | input | 1 | Static: 0 = toggle-triggered interrupt, 1 = doorbell verb |
| multi_stream | input | 1 | Static: 0 = single pair at node 0x01, 1 = one pair per converter node |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Always 1 |
| cmd_node | input | 8 | Target node number |
| cmd_verb | input | 12 | Verb code |
| cmd_data | input | 8 | Payload byte |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Response word |
| irq_ack | input | NUM_CVT | Per-pair interrupt acknowledge |
| irq_o | output | NUM_CVT | Per-pair sticky interrupt flag |
| fmt_o | output | 16*NUM_CVT | Audio format word of each pair |
| fmt_valid_o | output | NUM_CVT | Format valid flag of each pair |

## Verification
Several rules are checked on every cycle by assertions:
- every accepted command has exactly one response strobe;
- the format pins stay still while no command arrives;
- an interrupt flag never rises without a command in the previous cycle;
- in doorbell style, a rise always follows a nonzero 0xF80;
- a flag holds until acknowledged, and an acknowledge on a cycle with no command clears it.

Other properties need the bench's scenarios:
- the byte lanes and whole-word readback;
- the toggle rule, where a repeated bit value must stay quiet;
- the simultaneous acknowledge and trigger case;
- node filtering in both addressing styles;
- pair independence.

// File: rtl/vsr_pkg.sv
`timescale 1ns/1ps
package vsr_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_RD0,
    OP_RD1,
    OP_WR0,
    OP_WR1,
    OP_DOORBELL
  } vsr_op_e;

  localparam logic [11:0] VERB_RD0      = 12'hFA6;
  localparam logic [11:0] VERB_WR0_LO   = 12'hFA7;
  localparam logic [11:0] VERB_WR0_HI   = 12'hFAA;
  localparam logic [11:0] VERB_RD1      = 12'hFAB;
  localparam logic [11:0] VERB_WR1_LO   = 12'hFAC;
  localparam logic [11:0] VERB_WR1_HI   = 12'hFAF;
  localparam logic [11:0] VERB_DOORBELL = 12'hF80;
  localparam logic [7:0]  SINGLE_NODE   = 8'h01;

  localparam int WORD_W    = 32;
  localparam int FMT_W     = 16;
  localparam int TRIG_BIT  = 31;
  localparam int VALID_BIT = 30;
endpackage

// File: rtl/vsr_verb_decode.sv
`timescale 1ns/1ps
module vsr_verb_decode
  import vsr_pkg::*;
(
  input  logic [11:0] verb,
  output vsr_op_e     op,
  output logic [1:0]  byte_sel
);
  always_comb begin
    op       = OP_NONE;
    byte_sel = 2'd0;
    if (verb == VERB_RD0) begin
      op = OP_RD0;
    end else if (verb == VERB_RD1) begin
      op = OP_RD1;
    end else if (verb >= VERB_WR0_LO && verb <= VERB_WR0_HI) begin
      op       = OP_WR0;
      byte_sel = verb[1:0] + 2'd1;   // 0xFA7 -> lane 0 ... 0xFAA -> lane 3
    end else if (verb >= VERB_WR1_LO && verb <= VERB_WR1_HI) begin
      op       = OP_WR1;
      byte_sel = verb[1:0];          // 0xFAC -> lane 0 ... 0xFAF -> lane 3
    end else if (verb == VERB_DOORBELL) begin
      op = OP_DOORBELL;
    end
  end
endmodule

// File: rtl/vsr_node_match.sv
`timescale 1ns/1ps
module vsr_node_match
  import vsr_pkg::*;
#(
  parameter int                    NUM_CVT   = 2,
  parameter logic [NUM_CVT*8-1:0]  CVT_NODES = {8'h05, 8'h04}
) (
  input  logic [7:0]         node,
  input  logic               multi_stream,
  output logic [NUM_CVT-1:0] hit
);
  for (genvar i = 0; i < NUM_CVT; i++) begin : g_hit
    if (i == 0) begin : g_first
      assign hit[i] = multi_stream ? (node == CVT_NODES[i*8 +: 8])
                                   : (node == SINGLE_NODE);
    end else begin : g_rest
      assign hit[i] = multi_stream && (node == CVT_NODES[i*8 +: 8]);
    end
  end
endmodule

// File: rtl/vsr_bank.sv
`timescale 1ns/1ps
module vsr_bank
  import vsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  vsr_op_e           op,
  input  logic [1:0]        byte_sel,
  input  logic [7:0]        data,
  input  logic              doorbell_mode,
  input  logic              ack,
  output logic [WORD_W-1:0] word0,
  output logic [WORD_W-1:0] word1,
  output logic              irq
);
  logic toggle_hit;
  logic ring_hit;
  logic trig;

  always_comb begin
    toggle_hit = sel && !doorbell_mode && op == OP_WR0 && byte_sel == 2'd3
                 && (data[7] != word0[TRIG_BIT]);
    ring_hit   = sel && doorbell_mode && op == OP_DOORBELL && (data != 8'd0);
    trig       = toggle_hit || ring_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word0 <= '0;
      word1 <= '0;
      irq   <= 1'b0;
    end else begin
      if (sel && op == OP_WR0) word0[byte_sel*8 +: 8] <= data;
      if (sel && op == OP_WR1) word1[byte_sel*8 +: 8] <= data;
      irq <= trig || (irq && !ack);
    end
  end
endmodule

// File: rtl/vscratch_regs.sv
`timescale 1ns/1ps
module vscratch_regs
  import vsr_pkg::*;
#(
  parameter int                    NUM_CVT   = 2,
  parameter logic [NUM_CVT*8-1:0]  CVT_NODES = {8'h05, 8'h04}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     doorbell_mode,
  input  logic                     multi_stream,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [7:0]               cmd_node,
  input  logic [11:0]              cmd_verb,
  input  logic [7:0]               cmd_data,
  output logic                     rsp_valid,
  output logic [31:0]              rsp_data,
  input  logic [NUM_CVT-1:0]       irq_ack,
  output logic [NUM_CVT-1:0]       irq_o,
  output logic [NUM_CVT*16-1:0]    fmt_o,
  output logic [NUM_CVT-1:0]       fmt_valid_o
);
  vsr_op_e              op;
  logic [1:0]           byte_sel;
  logic [NUM_CVT-1:0]   hit;
  logic [WORD_W-1:0]    w0 [NUM_CVT];
  logic [WORD_W-1:0]    w1 [NUM_CVT];
  logic [WORD_W-1:0]    rsp_next;
  logic                 accept;

  assign cmd_ready = 1'b1;
  assign accept    = cmd_valid && cmd_ready;

  vsr_verb_decode u_dec (
    .verb     (cmd_verb),
    .op       (op),
    .byte_sel (byte_sel)
  );

  vsr_node_match #(.NUM_CVT(NUM_CVT), .CVT_NODES(CVT_NODES)) u_match (
    .node         (cmd_node),
    .multi_stream (multi_stream),
    .hit          (hit)
  );

  for (genvar i = 0; i < NUM_CVT; i++) begin : g_bank
    vsr_bank u_bank (
      .clk           (clk),
      .rst           (rst),
      .sel           (accept && hit[i]),
      .op            (op),
      .byte_sel      (byte_sel),
      .data          (cmd_data),
      .doorbell_mode (doorbell_mode),
      .ack           (irq_ack[i]),
      .word0         (w0[i]),
      .word1         (w1[i]),
      .irq           (irq_o[i])
    );
    assign fmt_o[i*FMT_W +: FMT_W] = w0[i][FMT_W-1:0];
    assign fmt_valid_o[i]          = w0[i][VALID_BIT];
  end

  always_comb begin
    rsp_next = '0;
    for (int i = 0; i < NUM_CVT; i++) begin
      if (hit[i] && op == OP_RD0) rsp_next = rsp_next | w0[i];
      if (hit[i] && op == OP_RD1) rsp_next = rsp_next | w1[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= accept;
      rsp_data  <= accept ? rsp_next : '0;
    end
  end
endmodule

// File: rtl/vsr_checker.sv
`timescale 1ns/1ps
module vsr_checker #(
  parameter int NUM_CVT = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  doorbell_mode,
  input logic                  cmd_valid,
  input logic [11:0]           cmd_verb,
  input logic [7:0]            cmd_data,
  input logic                  rsp_valid,
  input logic [NUM_CVT-1:0]    irq_ack,
  input logic [NUM_CVT-1:0]    irq_o,
  input logic [NUM_CVT*16-1:0] fmt_o,
  input logic [NUM_CVT-1:0]    fmt_valid_o
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!rsp_valid && irq_o == '0));

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> rsp_valid);

  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !rsp_valid);

  p_quiet_fmt_r5: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> ($stable(fmt_o) && $stable(fmt_valid_o)));

  for (genvar i = 0; i < NUM_CVT; i++) begin : g_irq
    p_irq_cause_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_o[i]) |-> $past(cmd_valid));

    p_doorbell_only_r7: assert property (@(posedge clk) disable iff (rst)
      (doorbell_mode && $rose(irq_o[i])) |->
        ($past(cmd_verb) == 12'hF80 && $past(cmd_data) != 8'd0));

    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
      (irq_o[i] && !irq_ack[i]) |=> irq_o[i]);

    p_ack_clears_r10: assert property (@(posedge clk) disable iff (rst)
      (irq_ack[i] && !cmd_valid) |=> !irq_o[i]);
  end
endmodule

bind vscratch_regs vsr_checker #(.NUM_CVT(NUM_CVT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .doorbell_mode (doorbell_mode),
  .cmd_valid     (cmd_valid),
  .cmd_verb      (cmd_verb),
  .cmd_data      (cmd_data),
  .rsp_valid     (rsp_valid),
  .irq_ack       (irq_ack),
  .irq_o         (irq_o),
  .fmt_o         (fmt_o),
  .fmt_valid_o   (fmt_valid_o)
);

// File: tb/sim_vscratch_regs.sv
`timescale 1ns/1ps
module sim_vscratch_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        doorbell_mode = 1'b0;
  logic        multi_stream = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_node = 8'd0;
  logic [11:0] cmd_verb = 12'd0;
  logic [7:0]  cmd_data = 8'd0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [1:0]  irq_ack = 2'b00;
  logic [1:0]  irq_o;
  logic [31:0] fmt_o;
  logic [1:0]  fmt_valid_o;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [31:0] m0 [2];
  logic [31:0] m1 [2];
  logic [1:0]  mirq;

  always #2.5 clk = ~clk;

  vscratch_regs u0 (
    .clk(clk), .rst(rst), .doorbell_mode(doorbell_mode), .multi_stream(multi_stream),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_node(cmd_node),
    .cmd_verb(cmd_verb), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .irq_ack(irq_ack), .irq_o(irq_o), .fmt_o(fmt_o),
    .fmt_valid_o(fmt_valid_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int pair_of(input logic [7:0] node);
    if (multi_stream) return (node == 8'h04) ? 0 : (node == 8'h05) ? 1 : -1;
    return (node == 8'h01) ? 0 : -1;
  endfunction

  task automatic check_outputs(input string tag);
    chk(irq_o == mirq, {tag, " irq"}, 64'(irq_o), 64'(mirq));
    chk(fmt_o == {m0[1][15:0], m0[0][15:0]}, {tag, " fmt (R11)"}, 64'(fmt_o),
        64'({m0[1][15:0], m0[0][15:0]}));
    chk(fmt_valid_o == {m0[1][30], m0[0][30]}, {tag, " valid (R11)"}, 64'(fmt_valid_o),
        64'({m0[1][30], m0[0][30]}));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 2; i++) begin m0[i] = '0; m1[i] = '0; end
    mirq = '0;
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 0);
    chk(rsp_data == 32'd0, "R1 rsp_data", 64'(rsp_data), 0);
    check_outputs("R1");
  endtask

  task automatic run(input logic [7:0] node, input logic [11:0] verb, input logic [7:0] d,
                     input logic [1:0] ack, input string tag);
    int s;
    logic [31:0] exp_rsp;
    logic [1:0]  trig;
    s = pair_of(node);
    exp_rsp = '0;
    trig = '0;
    if (s >= 0) begin
      if (verb == 12'hFA6) exp_rsp = m0[s];
      else if (verb == 12'hFAB) exp_rsp = m1[s];
      else if (verb >= 12'hFA7 && verb <= 12'hFAA) begin
        if (verb == 12'hFAA && !doorbell_mode && d[7] != m0[s][31]) trig[s] = 1'b1;
        m0[s][8*int'(verb - 12'hFA7) +: 8] = d;
      end else if (verb >= 12'hFAC && verb <= 12'hFAF) begin
        m1[s][8*int'(verb - 12'hFAC) +: 8] = d;
      end else if (verb == 12'hF80 && doorbell_mode && d != 8'd0) begin
        trig[s] = 1'b1;
      end
    end
    mirq = trig | (mirq & ~ack);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_node = node; cmd_verb = verb; cmd_data = d; irq_ack = ack;
    chk(cmd_ready == 1'b1, {tag, " ready (R2)"}, 64'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 1'b0; irq_ack = 2'b00;
    chk(rsp_valid == 1'b1, {tag, " rsp_valid (R2)"}, 64'(rsp_valid), 1);
    chk(rsp_data == exp_rsp, {tag, " rsp_data"}, 64'(rsp_data), 64'(exp_rsp));
    check_outputs(tag);
  endtask

  task automatic ack_only(input logic [1:0] ack);
    mirq = mirq & ~ack;
    @(negedge clk);
    irq_ack = ack;
    @(negedge clk);
    irq_ack = 2'b00;
    chk(rsp_valid == 1'b0, "R2 idle rsp", 64'(rsp_valid), 0);
    check_outputs("R10 ack");
  endtask

  initial begin
    #900000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // ---- single stream, toggle style ----
    do_reset();
    run(8'h01, 12'hFA6, 8'h00, 2'b00, "R1 readback");
    for (int b = 0; b < 4; b++)
      for (int v = 0; v < 256; v += 15) begin
        run(8'h01, 12'hFA7 + 12'(b), 8'(v), 2'b01, "R3 write");
        run(8'h01, 12'hFA6, 8'h00, 2'b00, "R2 read0");
      end
    for (int b = 0; b < 4; b++)
      for (int v = 3; v < 256; v += 23) begin
        run(8'h01, 12'hFAC + 12'(b), 8'(v), 2'b00, "R4 write");
        run(8'h01, 12'hFAB, 8'h00, 2'b00, "R2 read1");
      end
    ack_only(2'b11);
    // R5 unrecognised verbs and nodes
    run(8'h01, 12'hFA5, 8'hFF, 2'b00, "R5 bad verb");
    run(8'h01, 12'hFB0, 8'hFF, 2'b00, "R5 bad verb");
    run(8'h02, 12'hFAA, 8'hFF, 2'b00, "R5 bad node");
    run(8'h01, 12'hF80, 8'h01, 2'b00, "R6 doorbell ignored");
    // R8 converter node not addressed in single mode
    run(8'h04, 12'hFA7, 8'h5A, 2'b00, "R8 node4 write");
    run(8'h04, 12'hFA6, 8'h00, 2'b00, "R8 node4 read");
    // R6 toggle rule
    run(8'h01, 12'hFAA, 8'h00, 2'b00, "R6 set low");
    ack_only(2'b01);
    run(8'h01, 12'hFAA, 8'h00, 2'b00, "R6 same low");
    run(8'h01, 12'hFAA, 8'h80, 2'b00, "R6 rise");
    ack_only(2'b01);
    run(8'h01, 12'hFAA, 8'hC0, 2'b00, "R6 same high");
    run(8'h01, 12'hFAA, 8'h40, 2'b00, "R6 fall");
    // R10 ack and trigger together keep flag
    run(8'h01, 12'hFAA, 8'hC0, 2'b01, "R10 ack+trig");
    run(8'h01, 12'hFA6, 8'h00, 2'b01, "R10 ack on read");
    run(8'h01, 12'hFA6, 8'h00, 2'b00, "R10 stays clear");

    // ---- single stream, doorbell style ----
    doorbell_mode = 1'b1;
    do_reset();
    run(8'h01, 12'hFAA, 8'h80, 2'b00, "R7 bit31 no trigger");
    run(8'h01, 12'hFAA, 8'h00, 2'b00, "R7 bit31 no trigger");
    run(8'h01, 12'hF80, 8'h00, 2'b00, "R7 zero payload");
    run(8'h02, 12'hF80, 8'h01, 2'b00, "R5 doorbell bad node");
    for (int v = 1; v < 256; v += 17) begin
      run(8'h01, 12'hF80, 8'(v), 2'b00, "R7 ring");
      run(8'h01, 12'hF80, 8'(v), 2'b01, "R10 ring+ack");
      ack_only(2'b01);
    end

    // ---- multi stream, toggle style ----
    doorbell_mode = 1'b0;
    multi_stream = 1'b1;
    do_reset();
    for (int n = 4; n < 6; n++)
      for (int b = 0; b < 4; b++) begin
        run(8'(n), 12'hFA7 + 12'(b), 8'(n * 16 + b * 3 + 1), 2'b00, "R9 write0");
        run(8'(n), 12'hFAC + 12'(b), 8'(n * 32 + b), 2'b00, "R9 write1");
        run(8'h04, 12'hFA6, 8'h00, 2'b00, "R9 read node4");
        run(8'h05, 12'hFA6, 8'h00, 2'b00, "R9 read node5");
        run(8'(n), 12'hFAB, 8'h00, 2'b00, "R9 read1");
      end
    run(8'h01, 12'hFA7, 8'hEE, 2'b00, "R9 node1 ignored");
    run(8'h01, 12'hFA6, 8'h00, 2'b00, "R9 node1 read");
    ack_only(2'b11);
    run(8'h05, 12'hFAA, 8'h00, 2'b00, "R9 node5 toggle");
    run(8'h04, 12'hFAA, 8'h80, 2'b10, "R9 node4 toggle");
    ack_only(2'b01);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule